// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a multicycle processor, built as a micro-program store walked by a micro-address counter. Every microinstruction in the store has two parts: a two-bit sequencing code that picks the next micro-address, and a word of datapath control bits that the block presents on its output for the whole time that microinstruction is current. The sequencing code has three useful values. It can send the counter back to the fetch entry at address zero. It can jump to an entry chosen by the six-bit operation code, using a small mapping table. It can step to the next address.

The store holds routines for five instruction classes: register arithmetic, OR with an immediate, load, store and branch-if-equal. All of them share a fetch step and a decode step. The decode step dispatches on the operation code, and each routine ends by returning to zero. A stall input freezes the sequencer so that a slow memory can stretch any step. The datapath and the memories are outside the block.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the micro-address `upc` becomes 0 and `ctl` becomes the fetch word 0x8010. The reset is synchronous.
- R2: Sequencing code 00 loads micro-address 0, code 01 loads the dispatch-table entry for the current `opcode`, code 10 loads the current address plus one, and code 11 holds the current address.
- R3: The dispatch table maps opcode 000000 to 4, 000100 to 3, 001101 to 6, 100011 to 8 and 101011 to 11. The opcode is sampled at the edge that leaves address 1.
- R4: Any opcode outside the dispatch table maps to address 0, so the sequencer goes back to fetch.
- R5: While `stall` is high at a rising edge, `upc` and `ctl` keep their values whatever the sequencing code and `opcode` are.
- R6: `ctl` is registered and always matches the current `upc`. Its bits are: [15] instruction-register load, [14] PC load, [13] PC branch-select, [12] A load, [11] B load, [10] compare-flag load, [9] sign-extend, [8] ALU immediate source, [7:6] ALU function (00 add, 01 subtract, 10 or, 11 from function field), [5] S load, [4] memory read, [3] memory write, [2] register-file write, [1] write-back from memory, [0] destination is rd.
- R7: Without stalls, the address sequences are 0,1,4,5 for register arithmetic, 0,1,6,7 for OR-immediate, 0,1,8,9,10 for load, 0,1,11,12 for store and 0,1,3 for branch. Each then returns to 0.
- R8: `ctl` per address: 0→0x8010, 1→0x1C00, 3→0x6000, 4→0x00E0, 5→0x4005, 6→0x01A0, 7→0x4004, 8→0x0320, 9→0x0010, 10→0x4006, 11→0x0320, 12→0x4008. The unused addresses give 0x0000.
- R9: Memory read and memory write are never asserted together on `ctl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Operation code of the instruction being decoded |
| stall | input | 1 | Freezes the micro-address and the control word |
| upc | output | 4 | Current micro-address |
| ctl | output | 16 | Datapath control bits of the current microinstruction |

## Verification
A wrong micro-address shows up on `upc` at the very next edge. From that edge on, `ctl` carries the word of a different step. A wrong dispatch entry therefore shows at the edge after decode as a wrong routine start. A missed return shows one edge after a routine's last step. A stall that leaks lets `upc` advance in the same cycle. Comparing both outputs every cycle against the expected walk catches each of these faults within one clock of its cause.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UPC_W = 4;
  localparam int OP_W  = 6;

  typedef enum logic [1:0] {
    SQ_ZERO = 2'b00,
    SQ_DISP = 2'b01,
    SQ_INC  = 2'b10,
    SQ_HOLD = 2'b11
  } seq_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_OR  = 2'b10,
    FN_FUN = 2'b11
  } alu_fn_e;

  typedef struct packed {
    logic    ir_load;
    logic    pc_load;
    logic    pc_branch;
    logic    a_load;
    logic    b_load;
    logic    cmp_load;
    logic    ext_sign;
    logic    alu_imm;
    alu_fn_e alu_fn;
    logic    s_load;
    logic    mem_rd;
    logic    mem_wr;
    logic    rf_wr;
    logic    wb_mem;
    logic    dst_rd;
  } ctl_t;

  typedef struct packed {
    seq_e seq;
    ctl_t ctl;
  } uword_t;

  localparam logic [OP_W-1:0] OPC_ALU  = 6'b000000;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STOR = 6'b101011;

  function automatic logic [UPC_W-1:0] dispatch_map(input logic [OP_W-1:0] op);
    case (op)
      OPC_ALU:  dispatch_map = 4'd4;
      OPC_BEQ:  dispatch_map = 4'd3;
      OPC_ORI:  dispatch_map = 4'd6;
      OPC_LOAD: dispatch_map = 4'd8;
      OPC_STOR: dispatch_map = 4'd11;
      default:  dispatch_map = 4'd0;
    endcase
  endfunction

  function automatic uword_t ucode(input int addr);
    uword_t w;
    w = '0;
    w.seq = SQ_ZERO;
    case (addr)
      0:  begin w.seq = SQ_INC;  w.ctl.ir_load = 1'b1; w.ctl.mem_rd = 1'b1; end
      1:  begin w.seq = SQ_DISP; w.ctl.a_load = 1'b1; w.ctl.b_load = 1'b1;
                w.ctl.cmp_load = 1'b1; end
      3:  begin w.ctl.pc_load = 1'b1; w.ctl.pc_branch = 1'b1; end
      4:  begin w.seq = SQ_INC;  w.ctl.alu_fn = FN_FUN; w.ctl.s_load = 1'b1; end
      5:  begin w.ctl.rf_wr = 1'b1; w.ctl.dst_rd = 1'b1; w.ctl.pc_load = 1'b1; end
      6:  begin w.seq = SQ_INC;  w.ctl.alu_imm = 1'b1; w.ctl.alu_fn = FN_OR;
                w.ctl.s_load = 1'b1; end
      7:  begin w.ctl.rf_wr = 1'b1; w.ctl.pc_load = 1'b1; end
      8, 11: begin w.seq = SQ_INC; w.ctl.ext_sign = 1'b1; w.ctl.alu_imm = 1'b1;
                w.ctl.alu_fn = FN_ADD; w.ctl.s_load = 1'b1; end
      9:  begin w.seq = SQ_INC;  w.ctl.mem_rd = 1'b1; end
      10: begin w.ctl.rf_wr = 1'b1; w.ctl.wb_mem = 1'b1; w.ctl.pc_load = 1'b1; end
      12: begin w.ctl.mem_wr = 1'b1; w.ctl.pc_load = 1'b1; end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int AW  = UPC_W
) (
  input  logic [OPW-1:0] op,
  output logic [AW-1:0]  target
);
  always_comb begin
    target = AW'(dispatch_map(op));
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  seq_e          seq,
  input  logic          stall,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (stall) begin
      nxt = cur;
    end else begin
      case (seq)
        SQ_ZERO: nxt = '0;
        SQ_DISP: nxt = disp;
        SQ_INC:  nxt = cur + 1'b1;
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output uword_t        word_q
);
  localparam int DEPTH = 1 << AW;
  localparam int WW    = $bits(uword_t);

  logic [WW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ucode(i);
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= ucode(0);
    else     word_q <= uword_t'(mem[addr]);
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int AW  = UPC_W,
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           stall,
  output logic [AW-1:0]  upc,
  output logic [15:0]    ctl
);
  logic [AW-1:0] upc_q;
  logic [AW-1:0] disp_addr;
  logic [AW-1:0] nxt_addr;
  uword_t        word_q;

  useq_dispatch #(.OPW(OPW), .AW(AW)) u_disp (
    .op     (opcode),
    .target (disp_addr)
  );

  useq_next #(.AW(AW)) u_next (
    .seq   (word_q.seq),
    .stall (stall),
    .cur   (upc_q),
    .disp  (disp_addr),
    .nxt   (nxt_addr)
  );

  useq_store #(.AW(AW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .addr   (nxt_addr),
    .word_q (word_q)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= nxt_addr;
  end

  assign upc = upc_q;
  assign ctl = word_q.ctl;

  // R1: synchronous reset lands on fetch
  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (upc_q == '0 && ctl == 16'h8010));

  // R5: stall freezes address and control word
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(upc_q) && $stable(ctl)));

  // R2: step code advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!stall && word_q.seq == SQ_INC) |=> upc_q == AW'($past(upc_q) + 1'b1));

  // R2: return code goes to fetch
  a_r2_return: assert property (@(posedge clk) disable iff (rst)
    (!stall && word_q.seq == SQ_ZERO) |=> upc_q == '0);

  // R3 / R4: dispatch follows the opcode table
  a_r3_dispatch: assert property (@(posedge clk) disable iff (rst)
    (!stall && word_q.seq == SQ_DISP) |=> upc_q == AW'(dispatch_map($past(opcode))));

  // R9: never read and write memory together
  a_r9_mem_excl: assert property (@(posedge clk) disable iff (rst)
    !(ctl[4] && ctl[3]));
endmodule

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic        stall = 1'b0;
  logic [3:0]  upc;
  logic [15:0] ctl;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  eu;
    logic [15:0] ec;
    string       rq;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;

  useq_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .stall(stall),
    .upc(upc), .ctl(ctl)
  );

  // expected control words, taken from R8
  function automatic logic [15:0] exp_ctl(input logic [3:0] a);
    case (a)
      4'd0:  return 16'h8010;
      4'd1:  return 16'h1C00;
      4'd3:  return 16'h6000;
      4'd4:  return 16'h00E0;
      4'd5:  return 16'h4005;
      4'd6:  return 16'h01A0;
      4'd7:  return 16'h4004;
      4'd8:  return 16'h0320;
      4'd9:  return 16'h0010;
      4'd10: return 16'h4006;
      4'd11: return 16'h0320;
      4'd12: return 16'h4008;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic push(input logic [3:0] eu, input string rq);
    item_t it;
    it.eu = eu; it.ec = exp_ctl(eu); it.rq = rq;
    sb.push_back(it);
  endtask

  task automatic tick(input logic st, input logic [5:0] op,
                      input logic [3:0] eu, input string rq);
    stall = st; opcode = op;
    @(posedge clk); #1;
    push(eu, rq);
  endtask

  task automatic run(input logic [5:0] op, input int n,
                     input logic [3:0] path [5], input string rq);
    tick(1'b0, op, 4'd1, rq);
    for (int k = 0; k < n; k++) tick(1'b0, op, path[k], rq);
  endtask

  // monitor: pops and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        total++;
        if (upc !== it.eu || ctl !== it.ec) begin
          bad++;
          $display("FAIL %s: upc=%0d ctl=%h expected upc=%0d ctl=%h",
                   it.rq, upc, ctl, it.eu, it.ec);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    push(4'd0, "R1");
    rst = 1'b0;
    // R7/R8/R3: each class walked to completion
    run(6'b000000, 3, '{4'd4, 4'd5, 4'd0, 4'd0, 4'd0}, "R7_alu");
    run(6'b001101, 3, '{4'd6, 4'd7, 4'd0, 4'd0, 4'd0}, "R7_ori");
    run(6'b100011, 4, '{4'd8, 4'd9, 4'd10, 4'd0, 4'd0}, "R7_load");
    run(6'b101011, 3, '{4'd11, 4'd12, 4'd0, 4'd0, 4'd0}, "R7_store");
    run(6'b000100, 2, '{4'd3, 4'd0, 4'd0, 4'd0, 4'd0}, "R3_beq");
    // R4: unknown opcodes fall back to fetch
    run(6'b111111, 1, '{4'd0, 4'd0, 4'd0, 4'd0, 4'd0}, "R4_unknown");
    run(6'b000001, 1, '{4'd0, 4'd0, 4'd0, 4'd0, 4'd0}, "R4_unknown");
    // R5: stall at fetch, decode, memory step and last step
    tick(1'b1, 6'b100011, 4'd0, "R5_fetch");
    tick(1'b1, 6'b100011, 4'd0, "R5_fetch");
    tick(1'b0, 6'b100011, 4'd1, "R5");
    tick(1'b1, 6'b100011, 4'd1, "R5_decode");
    tick(1'b1, 6'b000000, 4'd1, "R5_decode");
    tick(1'b0, 6'b101011, 4'd11, "R3_late_opcode");
    tick(1'b0, 6'b101011, 4'd12, "R7_store");
    tick(1'b1, 6'b101011, 4'd12, "R5_mem");
    tick(1'b0, 6'b101011, 4'd0, "R2_return");
    run(6'b100011, 2, '{4'd8, 4'd9, 4'd0, 4'd0, 4'd0}, "R7_load");
    tick(1'b1, 6'b000000, 4'd9, "R5_mem");
    tick(1'b1, 6'b000000, 4'd9, "R5_mem");
    tick(1'b0, 6'b000000, 4'd10, "R2_step");
    tick(1'b0, 6'b000000, 4'd0, "R2_return");
    // R1: reset mid-routine
    run(6'b000000, 1, '{4'd4, 4'd0, 4'd0, 4'd0, 4'd0}, "R7_alu");
    rst = 1'b1;
    tick(1'b0, 6'b000000, 4'd0, "R1_midway");
    rst = 1'b0;
    run(6'b001101, 3, '{4'd6, 4'd7, 4'd0, 4'd0, 4'd0}, "R6_ori");
    stall = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule